// File: doc/BRIEF.md
# Mixed Page-Size Associative TLB

This block is a fully associative address translation cache for a three-level, 39-bit virtual addressing scheme. Its virtual page number is three 9-bit chunks. Each of its entries maps a 4 KB, 2 MB or 1 GB page.

Several lookup ports work in parallel. Each port takes a virtual page number, an address-space ID (ASID) and a flag that disables the ASID comparison. One clock later the port returns the following:
- a hit flag,
- the physical page number, with the offset bits of a large page taken from the request,
- the permission and fault bits of the matching entry,
- a flag that marks a 4 KB entry.

A single refill port writes one entry from a page-walk result. The walker level sets the entry's 2-bit size code. The way to write is chosen by logic outside the block. A flush input invalidates every entry in one cycle.

Top module: `tlb_mixed_page`

## Requirements
- R1: On refill the walker level becomes the entry size code: level 0 (1 GB) gives 2'b11, level 1 (2 MB) gives 2'b01, and level 2 or 3 (4 KB) gives 2'b00.
- R2: An entry hits when all of the following hold:
  - its valid bit is set;
  - its top chunk (vpn[26:18]) equals the request's top chunk;
  - its middle chunk (vpn[17:9]) matches, unless size bit 1 is set;
  - its low chunk (vpn[8:0]) matches, unless size bit 0 is set.
- R3: The returned page number is assembled as follows:
  - bits [PPN_W-1:18] come from the entry;
  - bits [17:9] come from the request when size bit 1 is set, and from the entry otherwise;
  - bits [8:0] come from the request when size bit 0 is set, and from the entry otherwise.
- R4: A hit also requires the entry's stored ASID to equal `cur_asid`, unless that port's `rd_ignore_asid` is high.
- R5: On a hit, `resp_perm` returns the stored flags in this bit order: [8] page fault, [7] access fault, then d, a, g, u, x, w, r in bits 6 down to 0. Fault flags are reported unchanged on every hit.
- R6: `resp_normal` is high only on a hit whose entry has size code 2'b00.
- R7: When several entries match, the lowest-index entry supplies the response.
- R8: A flush invalidates every entry at the next edge. A refill in the same cycle as a flush leaves no valid entry.
- R9: `resp_valid` equals `rd_valid` one cycle earlier. A lookup sees the contents before the edge, so a refill becomes visible only to lookups issued in later cycles.
- R10: After reset no entry is valid and `resp_valid` is low.
- R11: A miss, or a cycle with no request, returns hit 0, page number 0, permissions 0 and normal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| cur_asid | input | ASID_W | Current address-space ID |
| rd_valid | input | N_PORTS | Lookup request per port |
| rd_vpn | input | N_PORTS*VPN_W | Virtual page number per port |
| rd_ignore_asid | input | N_PORTS | Skip the ASID comparison per port |
| wr_valid | input | 1 | Refill strobe |
| wr_way | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page number of the walk |
| wr_level | input | 2 | Walker level (0 = 1 GB, 1 = 2 MB, 2 = 4 KB) |
| wr_asid | input | ASID_W | ASID stored with the entry |
| wr_ppn | input | PPN_W | Physical page number from the walk |
| wr_perm | input | 7 | d,a,g,u,x,w,r (bit 6 to bit 0) |
| wr_pf | input | 1 | Page-fault flag from the walk |
| wr_af | input | 1 | Access-fault flag from the walk |
| resp_valid | output | N_PORTS | Response valid per port |
| resp_hit | output | N_PORTS | Hit per port |
| resp_ppn | output | N_PORTS*PPN_W | Translated page number per port |
| resp_perm | output | N_PORTS*9 | Fault and permission flags per port |
| resp_normal | output | N_PORTS | Hit entry is a 4 KB mapping |

## Verification
The checker runs every cycle and covers the timing and consistency rules:
- the one-cycle response timing, and that a hit or a 4 KB flag never appears without a response;
- the all-zero miss response;
- that a lookup issued right after a flush always misses.

The other behaviours depend on what was written earlier, so only the bench scenarios against a reference model can show them. These are the level-to-size conversion, the chunk masking on a match, the page-number splice for large pages, ASID filtering, priority among overlapping entries, and flush winning over a simultaneous refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int CHUNK_W = 9;
    parameter int VPN_W   = 3 * CHUNK_W;
    parameter int PPN_W   = 24;
    parameter int ASID_W  = 16;
    localparam int PERM_W = 9;

    // Fault flags first, then the page-table permission bits.
    typedef struct packed {
        logic pf;
        logic af;
        logic d;
        logic a;
        logic g;
        logic u;
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic [1:0]        size;  // bit1: skip middle chunk, bit0: skip low chunk
        logic [PPN_W-1:0]  ppn;
        perm_t             perm;
    } entry_t;

    function automatic logic [1:0] size_of_level(input logic [1:0] lvl);
        logic [1:0] s;
        case (lvl)
            2'd0:    s = 2'b11;
            2'd1:    s = 2'b01;
            default: s = 2'b00;
        endcase
        return s;
    endfunction

    function automatic logic entry_hit(input entry_t e,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASID_W-1:0] asid,
                                       input logic ign_asid);
        logic top_eq, mid_eq, low_eq;
        top_eq = e.tag[VPN_W-1:2*CHUNK_W] == vpn[VPN_W-1:2*CHUNK_W];
        mid_eq = e.tag[2*CHUNK_W-1:CHUNK_W] == vpn[2*CHUNK_W-1:CHUNK_W];
        low_eq = e.tag[CHUNK_W-1:0] == vpn[CHUNK_W-1:0];
        return top_eq && (e.size[1] || mid_eq) && (e.size[0] || low_eq)
               && (ign_asid || e.asid == asid);
    endfunction

    function automatic logic [PPN_W-1:0] splice_ppn(input entry_t e,
                                                    input logic [VPN_W-1:0] vpn);
        logic [CHUNK_W-1:0] mid, low;
        mid = e.size[1] ? vpn[2*CHUNK_W-1:CHUNK_W] : e.ppn[2*CHUNK_W-1:CHUNK_W];
        low = e.size[0] ? vpn[CHUNK_W-1:0] : e.ppn[CHUNK_W-1:0];
        return {e.ppn[PPN_W-1:2*CHUNK_W], mid, low};
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_way,
    input  entry_t               wr_data,
    output entry_t               entries [N_ENTRIES],
    output logic [N_ENTRIES-1:0] valid
);

    entry_t                store [N_ENTRIES];
    logic [N_ENTRIES-1:0]  valid_q;

    // Flush dominates a simultaneous refill.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_way] <= wr_data;
        end
    end

    assign entries = store;
    assign valid   = valid_q;

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  entry_t               entries [N_ENTRIES],
    input  logic [N_ENTRIES-1:0] valid,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [ASID_W-1:0]    asid,
    input  logic                 ign_asid,
    output logic [N_ENTRIES-1:0] hit_vec
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && entry_hit(entries[g], vpn, asid, ign_asid);
    end

endmodule

// File: rtl/tlb_resp_stage.sv
module tlb_resp_stage
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [N_ENTRIES-1:0] hit_vec,
    input  entry_t               entries [N_ENTRIES],
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [PPN_W-1:0]     resp_ppn,
    output perm_t                resp_perm,
    output logic                 resp_normal
);

    logic [IDX_W-1:0] sel;
    logic             found;
    entry_t           chosen;

    // Scan downward so the lowest matching index is kept last.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign chosen = entries[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_ppn    <= '0;
            resp_perm   <= '0;
            resp_normal <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid && found) begin
                resp_hit    <= 1'b1;
                resp_ppn    <= splice_ppn(chosen, vpn);
                resp_perm   <= chosen.perm;
                resp_normal <= (chosen.size == 2'b00);
            end else begin
                resp_hit    <= 1'b0;
                resp_ppn    <= '0;
                resp_perm   <= '0;
                resp_normal <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tlb_mixed_page.sv
module tlb_mixed_page
    import tlb_pkg::*;
#(
    parameter int N_PORTS   = 2,
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic [ASID_W-1:0]          cur_asid,
    input  logic [N_PORTS-1:0]         rd_valid,
    input  logic [N_PORTS*VPN_W-1:0]   rd_vpn,
    input  logic [N_PORTS-1:0]         rd_ignore_asid,
    input  logic                       wr_valid,
    input  logic [IDX_W-1:0]           wr_way,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [1:0]                 wr_level,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  logic [6:0]                 wr_perm,
    input  logic                       wr_pf,
    input  logic                       wr_af,
    output logic [N_PORTS-1:0]         resp_valid,
    output logic [N_PORTS-1:0]         resp_hit,
    output logic [N_PORTS*PPN_W-1:0]   resp_ppn,
    output logic [N_PORTS*PERM_W-1:0]  resp_perm,
    output logic [N_PORTS-1:0]         resp_normal
);

    entry_t               new_entry;
    entry_t               entries [N_ENTRIES];
    logic [N_ENTRIES-1:0] valid;

    always_comb begin
        new_entry.tag  = wr_vpn;
        new_entry.asid = wr_asid;
        new_entry.size = size_of_level(wr_level);
        new_entry.ppn  = wr_ppn;
        new_entry.perm = perm_t'({wr_pf, wr_af, wr_perm});
    end

    tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (wr_valid),
        .wr_way  (wr_way),
        .wr_data (new_entry),
        .entries (entries),
        .valid   (valid)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [N_ENTRIES-1:0] hit_vec;
        perm_t                perm_q;

        tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
            .entries  (entries),
            .valid    (valid),
            .vpn      (rd_vpn[p*VPN_W +: VPN_W]),
            .asid     (cur_asid),
            .ign_asid (rd_ignore_asid[p]),
            .hit_vec  (hit_vec)
        );

        tlb_resp_stage #(.N_ENTRIES(N_ENTRIES)) u_resp (
            .clk         (clk),
            .rst         (rst),
            .req_valid   (rd_valid[p]),
            .vpn         (rd_vpn[p*VPN_W +: VPN_W]),
            .hit_vec     (hit_vec),
            .entries     (entries),
            .resp_valid  (resp_valid[p]),
            .resp_hit    (resp_hit[p]),
            .resp_ppn    (resp_ppn[p*PPN_W +: PPN_W]),
            .resp_perm   (perm_q),
            .resp_normal (resp_normal[p])
        );

        assign resp_perm[p*PERM_W +: PERM_W] = perm_q;
    end

endmodule

// File: rtl/tlb_mixed_page_checker.sv
module tlb_mixed_page_checker
    import tlb_pkg::*;
#(
    parameter int N_PORTS = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      flush,
    input logic [N_PORTS-1:0]        rd_valid,
    input logic [N_PORTS-1:0]        resp_valid,
    input logic [N_PORTS-1:0]        resp_hit,
    input logic [N_PORTS*PPN_W-1:0]  resp_ppn,
    input logic [N_PORTS*PERM_W-1:0] resp_perm,
    input logic [N_PORTS-1:0]        resp_normal
);

    // Cycles since reset released, saturating; gates looks into the past.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
        p_resp_timing_r9: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd1) |-> (resp_valid[p] == $past(rd_valid[p])));

        p_hit_needs_resp_r9: assert property (@(posedge clk) disable iff (rst)
            resp_hit[p] |-> resp_valid[p]);

        p_normal_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
            resp_normal[p] |-> resp_hit[p]);

        p_miss_zero_r11: assert property (@(posedge clk) disable iff (rst)
            !resp_hit[p] |-> (resp_ppn[p*PPN_W +: PPN_W] == '0
                              && resp_perm[p*PERM_W +: PERM_W] == '0
                              && !resp_normal[p]));

        p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && $past(flush, 2) && $past(rd_valid[p]))
            |-> !resp_hit[p]);
    end

endmodule

bind tlb_mixed_page tlb_mixed_page_checker #(.N_PORTS(N_PORTS)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .rd_valid    (rd_valid),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_ppn    (resp_ppn),
    .resp_perm   (resp_perm),
    .resp_normal (resp_normal)
);

// File: tb/tlb_mixed_page_bench.sv
`timescale 1ns/1ps
module tlb_mixed_page_bench;
    import tlb_pkg::*;

    localparam int NP = 2;
    localparam int NE = 16;
    localparam int IW = $clog2(NE);
    localparam int RW = 1 + PPN_W + 9 + 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst, flush, wr_valid, wr_pf, wr_af;
    logic [ASID_W-1:0]     cur_asid, wr_asid;
    logic [NP-1:0]         rd_valid, rd_ignore_asid;
    logic [NP*VPN_W-1:0]   rd_vpn;
    logic [IW-1:0]         wr_way;
    logic [VPN_W-1:0]      wr_vpn;
    logic [1:0]            wr_level;
    logic [PPN_W-1:0]      wr_ppn;
    logic [6:0]            wr_perm;
    logic [NP-1:0]         resp_valid, resp_hit, resp_normal;
    logic [NP*PPN_W-1:0]   resp_ppn;
    logic [NP*9-1:0]       resp_perm;

    tlb_mixed_page #(.N_PORTS(NP), .N_ENTRIES(NE)) u_tlb_mixed_page (
        .clk(clk), .rst(rst), .flush(flush), .cur_asid(cur_asid),
        .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_ignore_asid(rd_ignore_asid),
        .wr_valid(wr_valid), .wr_way(wr_way), .wr_vpn(wr_vpn), .wr_level(wr_level),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_perm(wr_perm), .wr_pf(wr_pf),
        .wr_af(wr_af), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_ppn(resp_ppn), .resp_perm(resp_perm), .resp_normal(resp_normal)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model built from the requirements.
    logic              mv    [NE];
    logic [VPN_W-1:0]  mtag  [NE];
    logic [1:0]        msz   [NE];
    logic [ASID_W-1:0] masid [NE];
    logic [PPN_W-1:0]  mppn  [NE];
    logic [8:0]        mperm [NE];

    function automatic logic [1:0] ref_size(input logic [1:0] lvl);
        if (lvl == 2'd0) return 2'b11;   // R1
        if (lvl == 2'd1) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [RW-1:0] ref_lookup(input logic [VPN_W-1:0] v,
                                                 input logic [ASID_W-1:0] a,
                                                 input logic ign);
        for (int i = 0; i < NE; i++) begin
            logic ok;
            ok = mv[i] && mtag[i][26:18] == v[26:18]
                 && (msz[i][1] || mtag[i][17:9] == v[17:9])
                 && (msz[i][0] || mtag[i][8:0] == v[8:0])
                 && (ign || masid[i] == a);
            if (ok) begin
                logic [PPN_W-1:0] pp;
                pp = {mppn[i][PPN_W-1:18],
                      msz[i][1] ? v[17:9] : mppn[i][17:9],
                      msz[i][0] ? v[8:0]  : mppn[i][8:0]};
                return {1'b1, pp, mperm[i], msz[i] == 2'b00};
            end
        end
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        flush = 1'b0; wr_valid = 1'b0; rd_valid = '0; rd_ignore_asid = '0;
    endtask

    task automatic look(input int p, input logic [VPN_W-1:0] v, input logic ign);
        rd_valid[p] = 1'b1;
        rd_vpn[p*VPN_W +: VPN_W] = v;
        rd_ignore_asid[p] = ign;
    endtask

    task automatic refill(input int way, input logic [VPN_W-1:0] v, input logic [1:0] lvl,
                          input logic [ASID_W-1:0] a, input logic [PPN_W-1:0] pp,
                          input logic [6:0] pm, input logic pf, input logic af);
        wr_valid = 1'b1; wr_way = IW'(way); wr_vpn = v; wr_level = lvl;
        wr_asid = a; wr_ppn = pp; wr_perm = pm; wr_pf = pf; wr_af = af;
    endtask

    // One clock: expectations from the pre-edge model, model update, then check.
    task automatic step(input string req);
        logic [RW-1:0] exp_r [NP];
        logic          exp_v [NP];
        for (int p = 0; p < NP; p++) begin
            exp_v[p] = rd_valid[p];
            exp_r[p] = rd_valid[p] ? ref_lookup(rd_vpn[p*VPN_W +: VPN_W], cur_asid,
                                                rd_ignore_asid[p]) : '0;
        end
        @(posedge clk);
        if (flush) begin
            for (int i = 0; i < NE; i++) mv[i] = 1'b0;
        end else if (wr_valid) begin
            mv[wr_way] = 1'b1; mtag[wr_way] = wr_vpn; msz[wr_way] = ref_size(wr_level);
            masid[wr_way] = wr_asid; mppn[wr_way] = wr_ppn;
            mperm[wr_way] = {wr_pf, wr_af, wr_perm};
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            logic [RW-1:0] act;
            act = {resp_hit[p], resp_ppn[p*PPN_W +: PPN_W], resp_perm[p*9 +: 9],
                   resp_normal[p]};
            check(resp_valid[p] == exp_v[p], "R9 valid", 64'(resp_valid[p]), 64'(exp_v[p]));
            check(act == exp_r[p], req, 64'(act), 64'(exp_r[p]));
        end
        idle();
    endtask

    function automatic logic [8:0] pick_chunk();
        case ($urandom_range(0, 3))
            0: return 9'h000;
            1: return 9'h001;
            2: return 9'h1FF;
            default: return 9'($urandom);
        endcase
    endfunction

    function automatic logic [8:0] pick_top();
        case ($urandom_range(0, 3))
            0: return 9'h011;
            1: return 9'h012;
            2: return 9'h1F0;
            default: return 9'h000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        for (int i = 0; i < NE; i++) begin
            mv[i] = 1'b0; mtag[i] = '0; msz[i] = '0; masid[i] = '0; mppn[i] = '0; mperm[i] = '0;
        end
        rd_vpn = '0; wr_way = '0; wr_vpn = '0; wr_level = '0; wr_asid = '0;
        wr_ppn = '0; wr_perm = '0; wr_pf = 1'b0; wr_af = 1'b0;
        cur_asid = 16'd1;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(resp_valid == '0, "R10 reset valid", 64'(resp_valid), 64'd0);

        // R10: empty after reset
        look(0, {9'h011, 9'h022, 9'h033}, 1'b1);
        step("R10 empty");

        // R9: refill not visible to same-cycle lookup; 1 GB at way 5
        refill(5, {9'h011, 9'h022, 9'h033}, 2'd0, 16'd1, 24'hABC123, 7'h7F, 1'b0, 1'b0);
        look(0, {9'h011, 9'h022, 9'h033}, 1'b0);
        step("R9 same-cycle refill");

        // R1 R2 R3: 1 GB masks both lower chunks and splices them
        look(0, {9'h011, 9'h1FF, 9'h000}, 1'b0);
        look(1, {9'h012, 9'h022, 9'h033}, 1'b0);
        step("R1 R2 R3 1GB");

        // R7: 2 MB at way 2 overlaps way 5; lowest index wins; fault flag R5
        refill(2, {9'h011, 9'h044, 9'h055}, 2'd1, 16'd1, 24'h123456, 7'h15, 1'b1, 1'b0);
        step("R7 refill");
        look(0, {9'h011, 9'h044, 9'h1AA}, 1'b0);
        look(1, {9'h011, 9'h045, 9'h055}, 1'b0);
        step("R7 R2 R3 R5 2MB priority");

        // R4 R5: 4 KB with other ASID and access fault
        refill(9, {9'h077, 9'h066, 9'h055}, 2'd2, 16'd2, 24'h0F0F0F, 7'h42, 1'b0, 1'b1);
        step("R4 refill");
        look(0, {9'h077, 9'h066, 9'h055}, 1'b0);
        look(1, {9'h077, 9'h066, 9'h055}, 1'b1);
        step("R4 R5 asid");

        // R6: normal flag; R2 low chunk mismatch on 4 KB
        cur_asid = 16'd2;
        look(0, {9'h077, 9'h066, 9'h055}, 1'b0);
        look(1, {9'h077, 9'h066, 9'h054}, 1'b0);
        step("R6 R2 4KB");
        cur_asid = 16'd1;

        // R1: level 3 behaves as 4 KB
        refill(0, {9'h100, 9'h101, 9'h102}, 2'd3, 16'd1, 24'h777777, 7'h01, 1'b0, 1'b0);
        step("R1 refill");
        look(0, {9'h100, 9'h101, 9'h102}, 1'b0);
        look(1, {9'h100, 9'h101, 9'h103}, 1'b0);
        step("R1 R6 level3");

        // R8: flush alone
        flush = 1'b1;
        step("R8 flush");
        look(0, {9'h011, 9'h022, 9'h033}, 1'b1);
        look(1, {9'h100, 9'h101, 9'h102}, 1'b1);
        step("R8 after flush");

        // R8: flush wins over refill in the same cycle
        refill(1, {9'h0AA, 9'h0BB, 9'h0CC}, 2'd2, 16'd1, 24'h111111, 7'h7F, 1'b0, 1'b0);
        flush = 1'b1;
        step("R8 flush+refill");
        look(0, {9'h0AA, 9'h0BB, 9'h0CC}, 1'b1);
        step("R8 flush wins");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 199) == 0) flush = 1'b1;
            if ($urandom_range(0, 2) == 0)
                refill(int'($urandom_range(0, NE - 1)),
                       {pick_top(), pick_chunk(), pick_chunk()},
                       2'($urandom_range(0, 3)), 16'($urandom_range(1, 2)),
                       24'($urandom), 7'($urandom), 1'($urandom), 1'($urandom));
            cur_asid = 16'($urandom_range(1, 2));
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 3) != 0) begin
                    logic [VPN_W-1:0] v;
                    int k;
                    k = int'($urandom_range(0, NE - 1));
                    if (mv[k] && $urandom_range(0, 1) == 1) begin
                        v = mtag[k];
                        if ($urandom_range(0, 1) == 1) v[17:9] = pick_chunk();
                        if ($urandom_range(0, 1) == 1) v[8:0] = pick_chunk();
                    end else begin
                        v = {pick_top(), pick_chunk(), pick_chunk()};
                    end
                    look(p, v, 1'($urandom_range(0, 1)));
                end
            end
            step("R2 R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule